// File: doc/BRIEF.md
# BCD Real-Time Clock Calendar

This block keeps wall-clock time and a calendar date, advancing once for every cycle in which a millisecond enable is high. Each field is held in packed binary-coded decimal: a three-digit millisecond count, seconds, minutes, hours on a 24-hour dial, day of month, month, and a four-digit year. Month lengths follow the Gregorian rules, including the century exceptions. The current value of every field is driven on output ports so that other logic can timestamp events.

Firmware uses a simple register port with one-cycle write and read strobes. Through it, firmware sets the time and date, programs an alarm compare value that covers day, hour, minute, second and millisecond, and selects a periodic interrupt rate. A read of the millisecond register freezes a copy of the coarser fields, so a read sequence returns a single coherent instant. The periodic interrupt is derived by a binary divider from a separate 1024 Hz enable input, and its rate is a power of two from 1 Hz to 512 Hz.

Register map (4-bit address, 16-bit data, BCD right-aligned): 0 millisecond, 1 second, 2 minute, 3 hour, 4 day, 5 month, 6 year, 7 to 11 alarm millisecond, second, minute, hour and day, 12 control (bit 0 alarm enable, bits 7:4 rate code), 13 status (bit 0 alarm flag).

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time reads 2000-01-01 00:00:00.000, the alarm flag and both interrupt outputs are low, `rdata` is zero, and control reads 0x00F0 (alarm disabled, rate code 15).
- R2: Each cycle with `ms_tick` high and no time write advances the millisecond field from 999 to 000 with a carry into seconds; seconds and minutes wrap after 59, hours wrap after 23, and every digit stays in 0..9.
- R3: Day wraps to 01 with a month carry after the last day of the month: 30 for April, June, September and November, 31 for the others, and for February 29 when the year is divisible by 4 but not by 100, or divisible by 400, and 28 otherwise; December wraps to January with a year carry.
- R4: The year counts in BCD, and 9999 advances to 0001.
- R5: A write to addresses 1 to 6 loads that field and sets the millisecond field to 000; a write to address 0 loads the millisecond field alone; a time write takes precedence over `ms_tick` in the same cycle.
- R6: `rdata` holds the value addressed by a read strobe from the next cycle on; a read of address 0 returns the live millisecond count and captures the other time fields, and reads of addresses 1 to 6 return the captured values.
- R7: When control bit 0 is set and the time newly equals the alarm day, hour, minute, second and millisecond, `alarm_irq` pulses for one cycle and the alarm flag is set, once per match, including a match in the next month; with bit 0 clear, nothing happens.
- R8: The alarm flag stays set until status is written with bit 0 one; a status write with bit 0 zero leaves it set.
- R9: With rate code n from 0 to 9 in control bits 7:4, `periodic_irq` pulses once per 2^(10-n) cycles of `rate_tick`, counted from the last control write; codes 10 to 15 give no pulses.
- R10: Alarm registers (addresses 7 to 11) and control (address 12) read back the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-millisecond advance enable |
| rate_tick | input | 1 | 1024 Hz enable for the periodic divider |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data, BCD right-aligned |
| rdata | output | 16 | Read data, valid the cycle after `rd_en` |
| alarm_irq | output | 1 | One-cycle pulse on an alarm match |
| alarm_flag | output | 1 | Sticky alarm status |
| periodic_irq | output | 1 | One-cycle periodic pulse |
| now_year | output | 16 | Current year, four BCD digits |
| now_month | output | 8 | Current month, BCD |
| now_day | output | 8 | Current day of month, BCD |
| now_hour | output | 8 | Current hour, BCD |
| now_min | output | 8 | Current minute, BCD |
| now_sec | output | 8 | Current second, BCD |
| now_ms | output | 12 | Current millisecond, three BCD digits |

## Verification
The time fields are exported directly, so a corrupted counter or a wrong carry shows on the `now_*` ports at the clock edge after the tick that caused it, and a bad month length or leap decision shows only when a run crosses that month's end. For this reason, runs are placed near day, month and year boundaries. An error in the capture register shows one cycle after the read of a coarser field, as a value that differs from the live time recorded at the millisecond read. Alarm and divider faults show as a wrong pulse count within one cycle of the matching tick or of the 2^(10-n)th rate tick.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 4;
    localparam int PRE_W  = 10;
    localparam int RATE_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_MS     = 4'd0,
        REG_SEC    = 4'd1,
        REG_MIN    = 4'd2,
        REG_HOUR   = 4'd3,
        REG_DAY    = 4'd4,
        REG_MON    = 4'd5,
        REG_YEAR   = 4'd6,
        REG_AL_MS  = 4'd7,
        REG_AL_SEC = 4'd8,
        REG_AL_MIN = 4'd9,
        REG_AL_HR  = 4'd10,
        REG_AL_DAY = 4'd11,
        REG_CTRL   = 4'd12,
        REG_STAT   = 4'd13
    } reg_addr_e;

    typedef struct packed {
        logic [15:0] year;
        logic [7:0]  month;
        logic [7:0]  day;
        logic [7:0]  hour;
        logic [7:0]  minute;
        logic [7:0]  sec;
        logic [11:0] ms;
    } rtc_time_t;

    typedef struct packed {
        logic [15:0] year;
        logic [7:0]  month;
        logic [7:0]  day;
        logic [7:0]  hour;
        logic [7:0]  minute;
        logic [7:0]  sec;
    } rtc_snap_t;

    typedef struct packed {
        logic [7:0]  day;
        logic [7:0]  hour;
        logic [7:0]  minute;
        logic [7:0]  sec;
        logic [11:0] ms;
    } rtc_alarm_t;

    localparam rtc_time_t TIME_AT_RESET = '{year: 16'h2000, month: 8'h01, day: 8'h01,
                                            hour: 8'h00, minute: 8'h00, sec: 8'h00,
                                            ms: 12'h000};

    localparam rtc_snap_t SNAP_AT_RESET = '{year: 16'h2000, month: 8'h01, day: 8'h01,
                                            hour: 8'h00, minute: 8'h00, sec: 8'h00};

    localparam rtc_alarm_t ALARM_AT_RESET = '{day: 8'h01, hour: 8'h00, minute: 8'h00,
                                              sec: 8'h00, ms: 12'h000};

    // Four-digit BCD increment; the carry out of the top digit is dropped.
    function automatic logic [15:0] bcd_inc(input logic [15:0] v);
        logic [15:0] r;
        logic        c;
        r = v;
        c = 1'b1;
        for (int i = 0; i < 4; i++) begin
            if (c) begin
                if (r[4*i +: 4] == 4'd9) begin
                    r[4*i +: 4] = 4'd0;
                end else begin
                    r[4*i +: 4] = r[4*i +: 4] + 4'd1;
                    c = 1'b0;
                end
            end
        end
        return r;
    endfunction

    // Leap test on BCD digits: a two-digit number 10a+b is a multiple of 4
    // exactly when 2a+b is; a year ending in 00 defers to the upper pair.
    function automatic logic bcd_leap(input logic [15:0] yr);
        logic [4:0] s;
        if (yr[7:0] != 8'h00) s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
        else                  s = {yr[15:12], 1'b0} + {1'b0, yr[11:8]};
        return s[1:0] == 2'b00;
    endfunction

    function automatic logic [7:0] bcd_last_day(input logic [7:0] mon, input logic [15:0] yr);
        case (mon)
            8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_rate_gen.sv
`timescale 1ns/1ps
module rtc_rate_gen
    import rtc_pkg::*;
#(
    parameter int DIV_W = PRE_W,
    parameter int SEL_W = RATE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rate_tick,
    input  logic             restart,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             pulse
);

    localparam logic [DIV_W-1:0] ALL_ONES = {DIV_W{1'b1}};

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] mask;
    logic             sel_ok;
    logic             fire;

    // Code n gives a window of DIV_W-n low bits, i.e. one pulse per 2^(DIV_W-n) ticks.
    assign mask   = ALL_ONES >> rate_sel;
    assign sel_ok = 32'(rate_sel) < 32'(DIV_W);
    assign fire   = rate_tick && !restart && sel_ok && ((cnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= fire;
            if (restart)        cnt <= '0;
            else if (rate_tick) cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rtc_alarm_unit.sv
`timescale 1ns/1ps
module rtc_alarm_unit
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       clear,
    input  rtc_time_t  now,
    input  rtc_alarm_t target,
    output logic       flag,
    output logic       irq
);

    logic match;
    logic match_d;
    logic fire;

    assign match = (now.day == target.day) && (now.hour == target.hour) &&
                   (now.minute == target.minute) && (now.sec == target.sec) &&
                   (now.ms == target.ms);

    // Only the first cycle of a match counts.
    assign fire = enable && match && !match_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            match_d <= 1'b0;
            irq     <= 1'b0;
            flag    <= 1'b0;
        end else begin
            match_d <= match;
            irq     <= fire;
            if (fire)       flag <= 1'b1;
            else if (clear) flag <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_time_chain.sv
`timescale 1ns/1ps
module rtc_time_chain
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              ld_en,
    input  reg_addr_e         ld_sel,
    input  logic [DATA_W-1:0] ld_val,
    output rtc_time_t         now
);

    rtc_time_t   cur;
    rtc_time_t   nxt;
    logic [15:0] inc_ms, inc_sec, inc_min, inc_hour, inc_day, inc_mon, inc_year;
    logic [7:0]  last_day;
    logic        w_ms, w_sec, w_min, w_hour, w_day, w_mon;

    always_comb begin
        inc_ms   = bcd_inc({4'h0, cur.ms});
        inc_sec  = bcd_inc({8'h00, cur.sec});
        inc_min  = bcd_inc({8'h00, cur.minute});
        inc_hour = bcd_inc({8'h00, cur.hour});
        inc_day  = bcd_inc({8'h00, cur.day});
        inc_mon  = bcd_inc({8'h00, cur.month});
        inc_year = bcd_inc(cur.year);
        last_day = bcd_last_day(cur.month, cur.year);

        w_ms   = cur.ms == 12'h999;
        w_sec  = w_ms   && (cur.sec == 8'h59);
        w_min  = w_sec  && (cur.minute == 8'h59);
        w_hour = w_min  && (cur.hour == 8'h23);
        w_day  = w_hour && (cur.day >= last_day);
        w_mon  = w_day  && (cur.month == 8'h12);

        nxt    = cur;
        nxt.ms = w_ms ? 12'h000 : inc_ms[11:0];
        if (w_ms)   nxt.sec    = w_sec  ? 8'h00 : inc_sec[7:0];
        if (w_sec)  nxt.minute = w_min  ? 8'h00 : inc_min[7:0];
        if (w_min)  nxt.hour   = w_hour ? 8'h00 : inc_hour[7:0];
        if (w_hour) nxt.day    = w_day  ? 8'h01 : inc_day[7:0];
        if (w_day)  nxt.month  = w_mon  ? 8'h01 : inc_mon[7:0];
        if (w_mon)  nxt.year   = (cur.year == 16'h9999) ? 16'h0001 : inc_year;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= TIME_AT_RESET;
        end else if (ld_en) begin
            if (ld_sel == REG_MS) begin
                cur.ms <= ld_val[11:0];
            end else begin
                cur.ms <= 12'h000;
                case (ld_sel)
                    REG_SEC:  cur.sec    <= ld_val[7:0];
                    REG_MIN:  cur.minute <= ld_val[7:0];
                    REG_HOUR: cur.hour   <= ld_val[7:0];
                    REG_DAY:  cur.day    <= ld_val[7:0];
                    REG_MON:  cur.month  <= ld_val[7:0];
                    REG_YEAR: cur.year   <= ld_val;
                    default:  ;
                endcase
            end
        end else if (tick) begin
            cur <= nxt;
        end
    end

    assign now = cur;

endmodule

// File: rtl/bcd_rtc.sv
`timescale 1ns/1ps
module bcd_rtc
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ms_tick,
    input  logic              rate_tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              alarm_irq,
    output logic              alarm_flag,
    output logic              periodic_irq,
    output logic [15:0]       now_year,
    output logic [7:0]        now_month,
    output logic [7:0]        now_day,
    output logic [7:0]        now_hour,
    output logic [7:0]        now_min,
    output logic [7:0]        now_sec,
    output logic [11:0]       now_ms
);

    reg_addr_e         a_sel;
    rtc_time_t         now;
    rtc_snap_t         shadow;
    rtc_alarm_t        alm;
    logic              ctrl_en;
    logic [RATE_W-1:0] ctrl_rate;
    logic [DATA_W-1:0] rd_mux;
    logic              wr_time;
    logic              flag_clr;
    logic              rate_restart;

    assign a_sel        = reg_addr_e'(addr);
    assign wr_time      = wr_en && (a_sel inside {REG_MS, REG_SEC, REG_MIN, REG_HOUR,
                                                  REG_DAY, REG_MON, REG_YEAR});
    assign flag_clr     = wr_en && (a_sel == REG_STAT) && wdata[0];
    assign rate_restart = wr_en && (a_sel == REG_CTRL);

    rtc_time_chain u_chain (
        .clk    (clk),
        .rst    (rst),
        .tick   (ms_tick),
        .ld_en  (wr_time),
        .ld_sel (a_sel),
        .ld_val (wdata),
        .now    (now)
    );

    rtc_alarm_unit u_alarm (
        .clk    (clk),
        .rst    (rst),
        .enable (ctrl_en),
        .clear  (flag_clr),
        .now    (now),
        .target (alm),
        .flag   (alarm_flag),
        .irq    (alarm_irq)
    );

    rtc_rate_gen #(
        .DIV_W (PRE_W),
        .SEL_W (RATE_W)
    ) u_rate (
        .clk       (clk),
        .rst       (rst),
        .rate_tick (rate_tick),
        .restart   (rate_restart),
        .rate_sel  (ctrl_rate),
        .pulse     (periodic_irq)
    );

    always_comb begin
        case (a_sel)
            REG_MS:     rd_mux = {4'h0, now.ms};
            REG_SEC:    rd_mux = {8'h00, shadow.sec};
            REG_MIN:    rd_mux = {8'h00, shadow.minute};
            REG_HOUR:   rd_mux = {8'h00, shadow.hour};
            REG_DAY:    rd_mux = {8'h00, shadow.day};
            REG_MON:    rd_mux = {8'h00, shadow.month};
            REG_YEAR:   rd_mux = shadow.year;
            REG_AL_MS:  rd_mux = {4'h0, alm.ms};
            REG_AL_SEC: rd_mux = {8'h00, alm.sec};
            REG_AL_MIN: rd_mux = {8'h00, alm.minute};
            REG_AL_HR:  rd_mux = {8'h00, alm.hour};
            REG_AL_DAY: rd_mux = {8'h00, alm.day};
            REG_CTRL:   rd_mux = {8'h00, ctrl_rate, 3'b000, ctrl_en};
            REG_STAT:   rd_mux = {15'h0000, alarm_flag};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alm       <= ALARM_AT_RESET;
            ctrl_en   <= 1'b0;
            ctrl_rate <= '1;
            shadow    <= SNAP_AT_RESET;
            rdata     <= '0;
        end else begin
            if (wr_en) begin
                case (a_sel)
                    REG_AL_MS:  alm.ms     <= wdata[11:0];
                    REG_AL_SEC: alm.sec    <= wdata[7:0];
                    REG_AL_MIN: alm.minute <= wdata[7:0];
                    REG_AL_HR:  alm.hour   <= wdata[7:0];
                    REG_AL_DAY: alm.day    <= wdata[7:0];
                    REG_CTRL: begin
                        ctrl_en   <= wdata[0];
                        ctrl_rate <= wdata[7:4];
                    end
                    default: ;
                endcase
            end
            if (rd_en) begin
                rdata <= rd_mux;
                if (a_sel == REG_MS) begin
                    shadow <= '{year: now.year, month: now.month, day: now.day,
                                hour: now.hour, minute: now.minute, sec: now.sec};
                end
            end
        end
    end

    assign now_year  = now.year;
    assign now_month = now.month;
    assign now_day   = now.day;
    assign now_hour  = now.hour;
    assign now_min   = now.minute;
    assign now_sec   = now.sec;
    assign now_ms    = now.ms;

endmodule

// File: rtl/rtc_checker.sv
`timescale 1ns/1ps
module rtc_checker (
    input logic        clk,
    input logic        rst,
    input logic        ms_tick,
    input logic        wr_en,
    input logic [3:0]  addr,
    input logic [15:0] wdata,
    input logic [15:0] now_year,
    input logic [7:0]  now_month,
    input logic [7:0]  now_day,
    input logic [7:0]  now_hour,
    input logic [7:0]  now_min,
    input logic [7:0]  now_sec,
    input logic [11:0] now_ms,
    input logic        alarm_irq,
    input logic        alarm_flag,
    input logic        periodic_irq,
    input logic [3:0]  ctrl_rate
);

    a_r2_ms_digits: assert property (@(posedge clk) disable iff (rst)
        (now_ms[3:0] <= 4'd9) && (now_ms[7:4] <= 4'd9) && (now_ms[11:8] <= 4'd9));

    a_r2_hour_range: assert property (@(posedge clk) disable iff (rst)
        (now_hour <= 8'h23) && (now_hour[3:0] <= 4'd9));

    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!ms_tick && !wr_en) |=>
        $stable({now_year, now_month, now_day, now_hour, now_min, now_sec, now_ms}));

    a_r3_date_range: assert property (@(posedge clk) disable iff (rst)
        (now_day != 8'h00) && (now_day <= 8'h31) &&
        (now_month != 8'h00) && (now_month <= 8'h12));

    a_r5_write_clears_ms: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr >= 4'd1) && (addr <= 4'd6)) |=> (now_ms == 12'h000));

    a_r7_irq_sets_flag: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |-> alarm_flag);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |=> !alarm_irq);

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && !(wr_en && (addr == 4'd13) && wdata[0])) |=> alarm_flag);

    a_r9_rate_off: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rate > 4'd9) |=> !periodic_irq);

endmodule

bind bcd_rtc rtc_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .ms_tick      (ms_tick),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .now_year     (now_year),
    .now_month    (now_month),
    .now_day      (now_day),
    .now_hour     (now_hour),
    .now_min      (now_min),
    .now_sec      (now_sec),
    .now_ms       (now_ms),
    .alarm_irq    (alarm_irq),
    .alarm_flag   (alarm_flag),
    .periodic_irq (periodic_irq),
    .ctrl_rate    (ctrl_rate)
);

// File: tb/bcd_rtc_test.sv
`timescale 1ns/1ps
module bcd_rtc_test;

    localparam logic [3:0] A_MS = 4'd0, A_SEC = 4'd1, A_MIN = 4'd2, A_HOUR = 4'd3,
                           A_DAY = 4'd4, A_MON = 4'd5, A_YEAR = 4'd6,
                           A_AMS = 4'd7, A_ASEC = 4'd8, A_AMIN = 4'd9, A_AHR = 4'd10,
                           A_ADAY = 4'd11, A_CTRL = 4'd12, A_STAT = 4'd13;

    logic        clk = 1'b0;
    logic        rst, ms_tick, rate_tick, wr_en, rd_en;
    logic [3:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        alarm_irq, alarm_flag, periodic_irq;
    logic [15:0] now_year;
    logic [7:0]  now_month, now_day, now_hour, now_min, now_sec;
    logic [11:0] now_ms;

    int n_checks = 0;
    int n_fail   = 0;
    int alarm_pulses = 0;
    int per_pulses   = 0;
    int m_y, m_mo, m_d, m_h, m_mi, m_s, m_ms;

    always #2.5 clk = ~clk;

    bcd_rtc uut (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .rate_tick(rate_tick),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .alarm_irq(alarm_irq), .alarm_flag(alarm_flag), .periodic_irq(periodic_irq),
        .now_year(now_year), .now_month(now_month), .now_day(now_day),
        .now_hour(now_hour), .now_min(now_min), .now_sec(now_sec), .now_ms(now_ms)
    );

    always @(negedge clk) begin
        if (alarm_irq)    alarm_pulses++;
        if (periodic_irq) per_pulses++;
    end

    // ---------------- reference model ----------------
    function automatic logic [15:0] to_bcd(input int v);
        logic [15:0] r;
        int t;
        t = v;
        r = '0;
        for (int i = 0; i < 4; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic bit is_leap(input int y);
        return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return is_leap(y) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic model_tick();
        m_ms++;
        if (m_ms == 1000) begin
            m_ms = 0; m_s++;
            if (m_s == 60) begin
                m_s = 0; m_mi++;
                if (m_mi == 60) begin
                    m_mi = 0; m_h++;
                    if (m_h == 24) begin
                        m_h = 0; m_d++;
                        if (m_d > mdays(m_mo, m_y)) begin
                            m_d = 1; m_mo++;
                            if (m_mo == 13) begin
                                m_mo = 1;
                                m_y = (m_y == 9999) ? 1 : m_y + 1;
                            end
                        end
                    end
                end
            end
        end
    endtask

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input string what,
                            input logic [63:0] act, input logic [63:0] exp);
        check(act == exp, req, what, act, exp);
    endtask

    task automatic check_time(input string req, input string what);
        logic [15:0] b_y, b_mo, b_d, b_h, b_mi, b_s, b_ms;
        b_y = to_bcd(m_y); b_mo = to_bcd(m_mo); b_d = to_bcd(m_d);
        b_h = to_bcd(m_h); b_mi = to_bcd(m_mi); b_s = to_bcd(m_s); b_ms = to_bcd(m_ms);
        check_eq(req, {what, " date"}, {32'h0, now_year, now_month, now_day},
                 {32'h0, b_y, b_mo[7:0], b_d[7:0]});
        check_eq(req, {what, " time"}, {28'h0, now_hour, now_min, now_sec, now_ms},
                 {28'h0, b_h[7:0], b_mi[7:0], b_s[7:0], b_ms[11:0]});
    endtask

    task automatic wrap_up();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // ---------------- bus and tick drivers (called at a falling edge) ----------------
    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic run_ticks(input int n);
        if (n > 0) begin
            ms_tick = 1'b1;
            repeat (n) @(negedge clk);
            ms_tick = 1'b0;
            for (int i = 0; i < n; i++) model_tick();
        end
    endtask

    task automatic run_rate(input int n);
        if (n > 0) begin
            rate_tick = 1'b1;
            repeat (n) @(negedge clk);
            rate_tick = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic program_time(input int y, input int mo, input int d, input int h,
                                input int mi, input int s, input int ms);
        bus_write(A_YEAR, to_bcd(y));
        bus_write(A_MON,  to_bcd(mo));
        bus_write(A_DAY,  to_bcd(d));
        bus_write(A_HOUR, to_bcd(h));
        bus_write(A_MIN,  to_bcd(mi));
        bus_write(A_SEC,  to_bcd(s));
        bus_write(A_MS,   to_bcd(ms));
        m_y = y; m_mo = mo; m_d = d; m_h = h; m_mi = mi; m_s = s; m_ms = ms;
    endtask

    task automatic rate_case(input int code, input int k);
        int expn;
        bus_write(A_CTRL, {8'h00, 4'(code), 4'h0});
        per_pulses = 0;
        run_rate(k);
        expn = (code <= 9) ? k / (1 << (10 - code)) : 0;
        check_eq("R9", $sformatf("pulses code %0d over %0d ticks", code, k),
                 64'(per_pulses), 64'(expn));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (180000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        wrap_up();
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [15:0] rd;
        int y, mo, d, h, mi, s, ms, n;
        int unsigned seed_dummy;

        seed_dummy = $urandom(32'd20240611);
        rst = 1'b1; ms_tick = 1'b0; rate_tick = 1'b0;
        wr_en = 1'b0; rd_en = 1'b0; addr = 4'd0; wdata = 16'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        m_y = 2000; m_mo = 1; m_d = 1; m_h = 0; m_mi = 0; m_s = 0; m_ms = 0;
        check_time("R1", "reset");
        check_eq("R1", "flag and irqs", {61'h0, alarm_flag, alarm_irq, periodic_irq}, 64'h0);
        check_eq("R1", "rdata", 64'(rdata), 64'h0);
        bus_read(A_CTRL, rd);
        check_eq("R1", "control reset", 64'(rd), 64'h00F0);

        // R2: ms/sec/min carry and hour wrap
        program_time(2023, 6, 10, 12, 34, 56, 990);
        run_ticks(15);
        check_time("R2", "second carry");
        program_time(2023, 6, 10, 23, 59, 59, 999);
        run_ticks(1);
        check_time("R2", "hour wrap to next day");
        check_eq("R2", "hour after midnight", 64'(now_hour), 64'h00);

        // R3: month lengths and leap rules
        program_time(2000, 2, 28, 23, 59, 59, 999); run_ticks(1);
        check_eq("R3", "year 2000 is leap", {48'h0, now_month, now_day}, 64'h0229);
        program_time(1900, 2, 28, 23, 59, 59, 999); run_ticks(1);
        check_eq("R3", "year 1900 not leap", {48'h0, now_month, now_day}, 64'h0301);
        program_time(2023, 2, 28, 23, 59, 59, 999); run_ticks(1);
        check_time("R3", "2023 Feb end");
        program_time(2024, 2, 29, 23, 59, 59, 999); run_ticks(1);
        check_time("R3", "2024 Feb 29 end");
        program_time(2023, 4, 30, 23, 59, 59, 999); run_ticks(1);
        check_time("R3", "30-day month end");
        program_time(2023, 12, 31, 23, 59, 59, 999); run_ticks(1);
        check_time("R3", "year end");

        // R4: top of the year range
        program_time(9999, 12, 31, 23, 59, 59, 999); run_ticks(1);
        check_eq("R4", "9999 rolls to 0001",
                 {16'h0, now_year, now_month, now_day, now_hour, now_min},
                 {16'h0, 16'h0001, 8'h01, 8'h01, 8'h00, 8'h00});
        program_time(1999, 12, 31, 23, 59, 59, 999); run_ticks(1);
        check_eq("R4", "BCD year carry", 64'(now_year), 64'h2000);

        // R5: loads clear ms, ms loads alone, write beats tick
        program_time(2023, 7, 1, 8, 0, 0, 0);
        run_ticks(5);
        bus_write(A_SEC, 16'h0042);
        m_s = 42; m_ms = 0;
        check_time("R5", "second load clears ms");
        bus_write(A_MS, 16'h0777);
        m_ms = 777;
        check_time("R5", "ms load keeps second");
        ms_tick = 1'b1; wr_en = 1'b1; addr = A_MIN; wdata = 16'h0015;
        @(negedge clk);
        ms_tick = 1'b0; wr_en = 1'b0;
        m_mi = 15; m_ms = 0;
        check_time("R5", "write wins over tick");

        // R6: coherent capture
        program_time(2024, 3, 15, 10, 20, 10, 995);
        bus_read(A_MS, rd);
        check_eq("R6", "live ms read", 64'(rd), 64'h0995);
        run_ticks(10);
        bus_read(A_SEC, rd);
        check_eq("R6", "captured second", 64'(rd), 64'h0010);
        check_eq("R6", "live second moved", 64'(now_sec), 64'h11);
        bus_read(A_MS, rd);
        check_eq("R6", "new ms read", 64'(rd), 64'h0005);
        bus_read(A_SEC, rd);
        check_eq("R6", "recaptured second", 64'(rd), 64'h0011);

        // R10: alarm and control readback
        bus_write(A_AMS,  16'h0050);
        bus_write(A_ASEC, 16'h0030);
        bus_write(A_AMIN, 16'h0020);
        bus_write(A_AHR,  16'h0010);
        bus_write(A_ADAY, 16'h0005);
        bus_write(A_CTRL, 16'h00F0);
        bus_read(A_AMS, rd);  check_eq("R10", "alarm ms",  64'(rd), 64'h0050);
        bus_read(A_AMIN, rd); check_eq("R10", "alarm min", 64'(rd), 64'h0020);
        bus_read(A_ADAY, rd); check_eq("R10", "alarm day", 64'(rd), 64'h0005);
        bus_read(A_CTRL, rd); check_eq("R10", "control",   64'(rd), 64'h00F0);

        // R7: disabled alarm stays silent
        program_time(2023, 5, 5, 10, 20, 30, 0);
        alarm_pulses = 0;
        run_ticks(100);
        repeat (3) @(negedge clk);
        check_eq("R7", "disabled: pulses and flag", {32'(alarm_pulses), 31'h0, alarm_flag}, 64'h0);

        // R7: enabled alarm fires once
        program_time(2023, 5, 5, 10, 20, 30, 0);
        bus_write(A_CTRL, 16'h00F1);
        alarm_pulses = 0;
        run_ticks(100);
        repeat (3) @(negedge clk);
        check_eq("R7", "enabled: one pulse", 64'(alarm_pulses), 64'd1);
        check_eq("R7", "enabled: flag set", 64'(alarm_flag), 64'd1);
        run_ticks(500);
        check_eq("R7", "no repeat pulse", 64'(alarm_pulses), 64'd1);

        // R8: sticky flag and write-one clear
        bus_write(A_STAT, 16'h0000);
        bus_read(A_STAT, rd);
        check_eq("R8", "zero write keeps flag", 64'(rd), 64'h0001);
        bus_write(A_STAT, 16'h0001);
        check_eq("R8", "one write clears flag", 64'(alarm_flag), 64'h0);

        // R7: alarm reaching into the next month
        bus_write(A_CTRL, 16'h00F0);
        program_time(2023, 1, 31, 23, 59, 59, 990);
        bus_write(A_AMS,  16'h0005);
        bus_write(A_ASEC, 16'h0000);
        bus_write(A_AMIN, 16'h0000);
        bus_write(A_AHR,  16'h0000);
        bus_write(A_ADAY, 16'h0001);
        bus_write(A_CTRL, 16'h00F1);
        alarm_pulses = 0;
        run_ticks(30);
        repeat (3) @(negedge clk);
        check_eq("R7", "next-month alarm", {32'(alarm_pulses), 31'h0, alarm_flag}, {32'd1, 32'd1});
        check_time("R3", "into February");
        bus_write(A_STAT, 16'h0001);
        bus_write(A_CTRL, 16'h00F0);

        // R9: periodic divider, directed
        rate_case(9, 64);
        rate_case(5, 100);
        rate_case(3, 300);
        rate_case(0, 2048);
        rate_case(12, 100);

        // R9: periodic divider, random
        for (int k = 0; k < 6; k++) begin
            rate_case(int'($urandom % 10), 1 + int'($urandom % 1500));
        end

        // R2/R3/R4/R6: random calendar runs near boundaries
        for (int k = 0; k < 24; k++) begin
            y  = 1 + int'($urandom % 9999);
            if (k % 6 == 0) y = 9999;
            mo = 1 + int'($urandom % 12);
            d  = 1 + int'($urandom % 32'(mdays(mo, y)));
            h  = int'($urandom % 24);
            mi = int'($urandom % 60);
            s  = int'($urandom % 60);
            ms = int'($urandom % 1000);
            if (k % 2 == 0) begin
                d = mdays(mo, y); h = 23; mi = 59; s = 59;
            end
            if (k % 6 == 0) mo = 12;
            if (k % 6 == 0) d = 31;
            n = 1 + int'($urandom % 1500);
            program_time(y, mo, d, h, mi, s, ms);
            run_ticks(n);
            check_time("R2", $sformatf("random run %0d", k));
            bus_read(A_MS, rd);
            check_eq("R6", "random ms read", 64'(rd), 64'(to_bcd(m_ms)));
            bus_read(A_YEAR, rd);
            check_eq("R4", "random year read", 64'(rd), 64'(to_bcd(m_y)));
            bus_read(A_DAY, rd);
            check_eq("R3", "random day read", 64'(rd), 64'(to_bcd(m_d)));
        end

        wrap_up();
    end

endmodule